// File: doc/BRIEF.md
# Nibble-Mixing Byte Permutation

This block maps one byte to another through a fixed, invertible substitution, entirely in combinational logic. The input byte is split into two nibbles. The nibbles pass through two rounds; each round mixes them with XOR and a one-bit rotate, then sends each one through its own 16-entry, 4-bit lookup table. The two nibbles left after the second round form the output byte. Because every lookup table is itself a permutation and every mixing step can be undone, the whole map is one-to-one over all 256 byte values.

A single parameter chooses between two variants that share the same datapath and differ only in their four lookup tables. The block is meant to be instantiated several times inside a larger key-dependent substitution stage, with each instance set to one variant. It has no clock: the output follows the input within the same cycle, and the surrounding logic decides where registers go.

Top module: `nib_byte_perm`

## Requirements
- R1: The input is split into an upper nibble A (din[7:4]) and a lower nibble B (din[3:0]). The first mix yields P = A xor B and Q = A xor rotr(B) xor {A[0],3'b000}, where rotr is a one-bit rotate right within four bits.
- R2: The second mix applies the same rule to the nibbles produced by the first lookup, giving P' = A' xor B' and Q' = A' xor rotr(B') xor {A'[0],3'b000}.
- R3: Lookups use four tables in order: table 0 maps P to A', table 1 maps Q to B', table 2 maps P' to the final low nibble, and table 3 maps Q' to the final high nibble. Each table is a permutation of 0..15.
- R4: The output is recombined with the table 3 result in dout[7:4] and the table 2 result in dout[3:0].
- R5: With VARIANT = 0, the tables (entry 0 first) are: table 0 = 8 1 7 D 6 F 3 2 0 B 5 9 E C A 4; table 1 = E C B 8 1 2 3 5 F 4 A 6 7 0 9 D; table 2 = B A 5 E 6 D 9 0 C 8 F 3 2 4 7 1; table 3 = D 7 F 4 1 2 6 E 9 B 3 0 8 5 C A. Input 0x00 maps to 0xA9.
- R6: With VARIANT = 1, the tables are: table 0 = 2 8 B D F 7 6 E 3 1 9 4 0 A C 5; table 1 = 1 E 2 B 4 C 3 7 6 D A 5 F 9 0 8; table 2 = 4 C 7 5 1 6 9 A 0 E D 8 2 B 3 F; table 3 = B 9 5 1 C 3 D E 6 4 7 F 2 0 8 A. Input 0x00 maps to 0x75.
- R7: For either variant, the 256 input values produce 256 distinct output values.
- R8: The output depends only on the present input: it settles within the cycle in which the input changes and stays unchanged while the input is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to be permuted |
| dout | output | 8 | Permuted byte |

## Verification
A wrong table entry or a misrouted mixing bit shows at the output in the very cycle the affected input is applied, since there is no state to delay it. A single bad entry in one table corrupts the result for sixteen of the 256 inputs and, unless it happens to swap two values, also breaks the one-to-one property, so a full sweep of both variants against an independent arithmetic model exposes it. A mix-up between the rotate direction, the shifted low bit or the output nibble order changes most results, and the fixed images of 0x00 pin down which variant is selected.

// File: rtl/nib_perm_pkg.sv
package nib_perm_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int NIB_N  = 1 << NIB_W;
  localparam int ROUNDS = 2;
  localparam int TBL_W  = NIB_W * NIB_N;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [TBL_W-1:0] tbl_t;

  // Entry 0 sits in the most significant nibble of each word.
  function automatic tbl_t table_word(input int variant, input int slot);
    tbl_t w;
    if (variant == 0) begin
      case (slot)
        0:       w = 64'h817D6F320B59ECA4;
        1:       w = 64'hECB81235F4A6709D;
        2:       w = 64'hBA5E6D90C8F32471;
        default: w = 64'hD7F4126E9B3085CA;
      endcase
    end else begin
      case (slot)
        0:       w = 64'h28BDF76E31940AC5;
        1:       w = 64'h1E2B4C376DA5F908;
        2:       w = 64'h4C75169A0ED82B3F;
        default: w = 64'hB951C3DE647F208A;
      endcase
    end
    return w;
  endfunction

  function automatic nib_t tbl_nib(input tbl_t w, input nib_t idx);
    return w[(TBL_W - 1 - NIB_W * int'(idx)) -: NIB_W];
  endfunction

  function automatic nib_t tbl_inv(input tbl_t w, input nib_t val);
    nib_t r;
    r = '0;
    for (int k = 0; k < NIB_N; k++) begin
      if (tbl_nib(w, nib_t'(k)) == val) r = nib_t'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/nib_mix_round.sv
module nib_mix_round
  import nib_perm_pkg::*;
(
  input  nib_t a_in,
  input  nib_t b_in,
  output nib_t p_out,
  output nib_t q_out
);

  nib_t b_rot;
  nib_t a_lsb_up;

  always_comb begin
    b_rot    = {b_in[0], b_in[NIB_W-1:1]};
    a_lsb_up = {a_in[0], {(NIB_W-1){1'b0}}};
    p_out    = a_in ^ b_in;
    q_out    = a_in ^ b_rot ^ a_lsb_up;
  end

  // R1/R2: a zero lower nibble leaves the sum as A and the mixed term as A plus its shifted low bit
  always_comb begin
    if (b_in == '0) begin
      assert_mix_zero_b_R1: assert (p_out == a_in && (q_out ^ a_in) == {a_in[0], 3'b000})
        else $error("mix with zero B broken");
    end
  end

  // R2: a zero upper nibble passes B straight and rotates it on the other side
  always_comb begin
    if (a_in == '0) begin
      assert_mix_zero_a_R2: assert (p_out == b_in && q_out[NIB_W-1] == b_in[0]
                                    && q_out[NIB_W-2:0] == b_in[NIB_W-1:1])
        else $error("mix with zero A broken");
    end
  end

endmodule

// File: rtl/nib_sbox.sv
module nib_sbox
  import nib_perm_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int SLOT    = 0
) (
  input  nib_t idx,
  output nib_t val
);

  localparam tbl_t WORD = table_word(VARIANT, SLOT);

  always_comb begin
    val = tbl_nib(WORD, idx);
  end

  // R3: every lookup can be undone by searching the table for its result
  always_comb begin
    assert_sbox_inverse_R3: assert (tbl_inv(WORD, val) == idx)
      else $error("table %0d lookup not invertible", SLOT);
  end

endmodule

// File: rtl/nib_byte_perm.sv
module nib_byte_perm
  import nib_perm_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [7:0] din,
  output logic [7:0] dout
);

  localparam logic [7:0] ZERO_IMG = (VARIANT == 0) ? 8'hA9 : 8'h75;

  nib_t hi_s [ROUNDS+1];
  nib_t lo_s [ROUNDS+1];

  assign hi_s[0] = din[BYTE_W-1:NIB_W];
  assign lo_s[0] = din[NIB_W-1:0];

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    nib_t p_mix;
    nib_t q_mix;

    nib_mix_round u_mix (
      .a_in  (hi_s[r]),
      .b_in  (lo_s[r]),
      .p_out (p_mix),
      .q_out (q_mix)
    );

    nib_sbox #(.VARIANT(VARIANT), .SLOT(2*r)) u_tbl_p (
      .idx (p_mix),
      .val (hi_s[r+1])
    );

    nib_sbox #(.VARIANT(VARIANT), .SLOT(2*r+1)) u_tbl_q (
      .idx (q_mix),
      .val (lo_s[r+1])
    );
  end

  assign dout = {lo_s[ROUNDS], hi_s[ROUNDS]};

  // R5 and R6: the all-zero byte lands on the fixed image of the chosen variant
  always_comb begin
    if (din == 8'h00) begin
      assert_zero_img_R5: assert (dout == ZERO_IMG)
        else $error("zero image %02h", dout);
    end
  end

  // R8: a known input never yields an unknown output
  always_comb begin
    if (!$isunknown(din)) begin
      assert_out_known_R8: assert (!$isunknown(dout))
        else $error("unknown output");
    end
  end

endmodule

// File: tb/nib_byte_perm_tb.sv
module nib_byte_perm_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] din;
  logic [7:0] dout0;
  logic [7:0] dout1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  nib_byte_perm #(.VARIANT(0)) u_dut     (.din(din), .dout(dout0));
  nib_byte_perm #(.VARIANT(1)) u_dut_alt (.din(din), .dout(dout1));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  longint unsigned tw [2][4];

  initial begin
    tw[0][0] = 64'h817D6F320B59ECA4; tw[0][1] = 64'hECB81235F4A6709D;
    tw[0][2] = 64'hBA5E6D90C8F32471; tw[0][3] = 64'hD7F4126E9B3085CA;
    tw[1][0] = 64'h28BDF76E31940AC5; tw[1][1] = 64'h1E2B4C376DA5F908;
    tw[1][2] = 64'h4C75169A0ED82B3F; tw[1][3] = 64'hB951C3DE647F208A;
  end

  function automatic int look(int v, int t, int i);
    return int'((tw[v][t] >> (60 - 4 * i)) % 16);
  endfunction

  function automatic int rotr4(int n);
    return (n / 2) + 8 * (n % 2);
  endfunction

  function automatic int ref_q(int v, int x);
    int a0, b0, a1, b1, a2, b2, a3, b3, a4, b4;
    a0 = x / 16;  b0 = x % 16;
    a1 = a0 ^ b0; b1 = a0 ^ rotr4(b0) ^ ((8 * a0) % 16);
    a2 = look(v, 0, a1); b2 = look(v, 1, b1);
    a3 = a2 ^ b2; b3 = a2 ^ rotr4(b2) ^ ((8 * a2) % 16);
    a4 = look(v, 2, a3); b4 = look(v, 3, b3);
    return 16 * b4 + a4;
  endfunction

  task automatic check(string tag, int got, int exp, int x);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s x=%02h actual %02h expected %02h", tag, x, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [255:0] seen0;
    bit [255:0] seen1;
    int         dup0;
    int         dup1;
    logic [7:0] held;
    seen0 = '0; seen1 = '0; dup0 = 0; dup1 = 0;
    rst_n = 1'b0;
    din   = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 / R6: fixed images of zero after reset
    check("R5 q0 zero image", dout0, 8'hA9, 0);
    check("R6 q1 zero image", dout1, 8'h75, 0);

    // R1 R2 R3 R4: full sweep of both variants against the arithmetic model, one new input each clock
    for (int x = 0; x < 256; x++) begin
      @(posedge clk);
      #1 din = 8'(x);
      @(negedge clk);
      check("R1 R2 R3 R4 R5 q0 sweep", dout0, ref_q(0, x), x);
      check("R1 R2 R3 R4 R6 q1 sweep", dout1, ref_q(1, x), x);
      if (seen0[dout0]) dup0++;
      if (seen1[dout1]) dup1++;
      seen0[dout0] = 1'b1;
      seen1[dout1] = 1'b1;
    end

    // R7: one-to-one over all bytes
    check("R7 q0 duplicate images", dup0, 0, 0);
    check("R7 q1 duplicate images", dup1, 0, 0);
    check("R7 q0 image count", $countones(seen0), 256, 0);
    check("R7 q1 image count", $countones(seen1), 256, 0);

    // R8: output holds while the input holds, and follows a change in the same cycle
    @(posedge clk);
    #1 din = 8'h5C;
    @(negedge clk);
    held = dout0;
    check("R8 same-cycle response", dout0, ref_q(0, 8'h5C), 8'h5C);
    repeat (4) begin
      @(negedge clk);
      check("R8 held output", dout0, held, 8'h5C);
    end
    @(posedge clk);
    #1 din = 8'hF1;
    @(negedge clk);
    check("R8 follows change q0", dout0, ref_q(0, 8'hF1), 8'hF1);
    check("R8 follows change q1", dout1, ref_q(1, 8'hF1), 8'hF1);

    finish_run();
  end

endmodule